// File: doc/BRIEF.md
# Memory-Mapped I/O Controller

This block connects the load/store port of a 32-bit processor to a small set of on-chip peripherals. Addresses inside a fixed I/O window are decoded exactly. A load returns the selected status, counter or received byte one clock later, like a synchronous memory. A store either writes a peripheral register or triggers an action. The action stores start a UART transmit, clear the performance counters, or write the LED and PWM-duty outputs.

Two performance counters live inside the block. The elapsed-cycle counter advances on every clock. The retired-instruction counter advances only when the pipeline asserts its count-enable, so bubbles and injected no-ops are not counted. On the UART side the block holds the byte handshake. It issues a one-cycle push strobe for every transmit store and a one-cycle pop strobe for every receive-data load.

Top module: `mmio_hub`

## Requirements
- R1: While reset is high and on the first cycle after it, `rdata`, `led_q`, `duty_q`, `tx_push`, `rx_pop` and both counters are zero.
- R2: A load from IO_BASE+0x00 returns a status word. Bit 0 is `tx_ready`, bit 1 is `rx_avail`, and bits 31:2 are zero.
- R3: A load from IO_BASE+0x04 returns `rx_byte` zero-extended. `rx_pop` is high for exactly the one cycle in which that byte appears on `rdata`.
- R4: A store to IO_BASE+0x08 sets `tx_byte` to `wdata[7:0]` and raises `tx_push` for exactly the one cycle after the store. `tx_byte` then holds its value.
- R5: The cycle counter increases by one on every clock edge that is neither in reset nor a clear. A load from IO_BASE+0x10 returns the value it held just before the load's clock edge.
- R6: Any store to IO_BASE+0x18 zeroes both counters. When a clear and an increment fall in the same cycle, the clear takes effect.
- R7: The instruction counter increases by one only on edges where `icount_en` is high. A load from IO_BASE+0x14 returns it.
- R8: A store to IO_BASE+0x30 loads `led_q` with the low LED_W bits of `wdata`. A store to IO_BASE+0x34 loads `duty_q` with the low DUTY_W bits. Loads from these two write-only addresses return zero.
- R9: A load from any unmapped address returns zero. A store to any unmapped address leaves `led_q`, `duty_q`, `tx_push` and the counters as they would otherwise be.
- R10: `rdata` changes only on the clock edge that samples a load. It keeps its value in cycles without a load.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 32 | Load/store byte address |
| wdata | input | 32 | Store data |
| st_en | input | 1 | Store request this cycle |
| ld_en | input | 1 | Load request this cycle |
| icount_en | input | 1 | A real instruction retires this cycle |
| rdata | output | 32 | Registered load data |
| tx_byte | output | 8 | Byte offered to the UART transmitter |
| tx_push | output | 1 | One-cycle transmit strobe |
| tx_ready | input | 1 | Transmitter can accept a byte |
| rx_byte | input | 8 | Byte held by the UART receiver |
| rx_avail | input | 1 | Receiver holds an unread byte |
| rx_pop | output | 1 | One-cycle receive-consume strobe |
| led_q | output | LED_W | LED register |
| duty_q | output | DUTY_W | PWM duty-cycle register |

## Verification
A counter clear can land in the same cycle as a counter increment: the free-running cycle step always does, and the instruction step does whenever `icount_en` is high. The bench stores to the clear address with `icount_en` held high and loads the instruction counter on the very next edge. A correct design returns zero; a design that lets the increment win returns one. The same load-after-clear sequence checks the cycle counter reads zero, and a second load one edge later must read one.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned BYTE_W = 8;

  localparam logic [XLEN-1:0] OFS_STAT = 32'h0000_0000;
  localparam logic [XLEN-1:0] OFS_RXD  = 32'h0000_0004;
  localparam logic [XLEN-1:0] OFS_TXD  = 32'h0000_0008;
  localparam logic [XLEN-1:0] OFS_CYC  = 32'h0000_0010;
  localparam logic [XLEN-1:0] OFS_INS  = 32'h0000_0014;
  localparam logic [XLEN-1:0] OFS_CLR  = 32'h0000_0018;
  localparam logic [XLEN-1:0] OFS_LED  = 32'h0000_0030;
  localparam logic [XLEN-1:0] OFS_DUTY = 32'h0000_0034;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_RXD,
    SEL_TXD,
    SEL_CYC,
    SEL_INS,
    SEL_CLR,
    SEL_LED,
    SEL_DUTY
  } io_sel_e;

  // Exact-match map of an address onto one I/O slot.
  function automatic io_sel_e sel_of(input logic [XLEN-1:0] a,
                                     input logic [XLEN-1:0] base);
    logic [XLEN-1:0] off;
    off = a - base;
    case (off)
      OFS_STAT: sel_of = SEL_STAT;
      OFS_RXD:  sel_of = SEL_RXD;
      OFS_TXD:  sel_of = SEL_TXD;
      OFS_CYC:  sel_of = SEL_CYC;
      OFS_INS:  sel_of = SEL_INS;
      OFS_CLR:  sel_of = SEL_CLR;
      OFS_LED:  sel_of = SEL_LED;
      OFS_DUTY: sel_of = SEL_DUTY;
      default:  sel_of = SEL_NONE;
    endcase
  endfunction

  // Status word: bit 0 transmit ready, bit 1 receive data pending.
  function automatic logic [XLEN-1:0] status_word(input logic tx_rdy,
                                                  input logic rx_av);
    status_word    = '0;
    status_word[0] = tx_rdy;
    status_word[1] = rx_av;
  endfunction
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter logic [XLEN-1:0] IO_BASE = 32'h8000_0000
) (
  input  logic [XLEN-1:0] addr,
  input  logic            ld_en,
  input  logic            st_en,
  output io_sel_e         rd_sel,
  output io_sel_e         wr_sel
);
  io_sel_e slot;

  always_comb begin
    slot   = sel_of(addr, IO_BASE);
    rd_sel = ld_en ? slot : SEL_NONE;
    wr_sel = st_en ? slot : SEL_NONE;
  end
endmodule

// File: rtl/mmio_counters.sv
module mmio_counters #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_CNT = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic [N_CNT-1:0]            inc,
  output logic [N_CNT-1:0][CNT_W-1:0] q
);
  // Clear has priority over the step.
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic clear,
                                            input logic bump);
    if (clear)     step = '0;
    else if (bump) step = cur + 1'b1;
    else           step = cur;
  endfunction

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) q[g] <= '0;
      else     q[g] <= step(q[g], clr, inc[g]);
    end
  end
endmodule

// File: rtl/mmio_uart_port.sv
module mmio_uart_port
  import mmio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              pop_req,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_push,
  output logic              rx_pop
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte <= '0;
      tx_push <= 1'b0;
      rx_pop  <= 1'b0;
    end else begin
      tx_push <= push_req;
      rx_pop  <= pop_req;
      if (push_req) tx_byte <= push_data;
    end
  end
endmodule

// File: rtl/mmio_hub.sv
module mmio_hub
  import mmio_pkg::*;
#(
  parameter logic [31:0] IO_BASE = 32'h8000_0000,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned LED_W   = 16,
  parameter int unsigned DUTY_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       addr,
  input  logic [31:0]       wdata,
  input  logic              st_en,
  input  logic              ld_en,
  input  logic              icount_en,
  output logic [31:0]       rdata,
  output logic [7:0]        tx_byte,
  output logic              tx_push,
  input  logic              tx_ready,
  input  logic [7:0]        rx_byte,
  input  logic              rx_avail,
  output logic              rx_pop,
  output logic [LED_W-1:0]  led_q,
  output logic [DUTY_W-1:0] duty_q
);
  localparam int unsigned N_CNT  = 2;
  localparam int unsigned CYC_IX = 0;
  localparam int unsigned INS_IX = 1;
  localparam int unsigned WIDEST = (LED_W > DUTY_W) ? LED_W : DUTY_W;

  io_sel_e rd_sel, wr_sel;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [N_CNT-1:0]            cnt_inc;
  logic [XLEN-1:0]             rd_next;

  // Named internal events, used by the bound checker.
  logic ev_clr, ev_tx_wr, ev_rx_rd, ev_led_wr, ev_duty_wr;
  logic unused_wdata_hi;

  mmio_decode #(.IO_BASE(IO_BASE)) u_dec (
    .addr   (addr),
    .ld_en  (ld_en),
    .st_en  (st_en),
    .rd_sel (rd_sel),
    .wr_sel (wr_sel)
  );

  assign ev_clr     = (wr_sel == SEL_CLR);
  assign ev_tx_wr   = (wr_sel == SEL_TXD);
  assign ev_rx_rd   = (rd_sel == SEL_RXD);
  assign ev_led_wr  = (wr_sel == SEL_LED);
  assign ev_duty_wr = (wr_sel == SEL_DUTY);

  assign cnt_inc[CYC_IX] = 1'b1;
  assign cnt_inc[INS_IX] = icount_en;

  mmio_counters #(.CNT_W(CNT_W), .N_CNT(N_CNT)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (ev_clr),
    .inc (cnt_inc),
    .q   (cnt_q)
  );

  mmio_uart_port u_uart (
    .clk       (clk),
    .rst       (rst),
    .push_req  (ev_tx_wr),
    .push_data (wdata[BYTE_W-1:0]),
    .pop_req   (ev_rx_rd),
    .tx_byte   (tx_byte),
    .tx_push   (tx_push),
    .rx_pop    (rx_pop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      led_q  <= '0;
      duty_q <= '0;
    end else begin
      if (ev_led_wr)  led_q  <= wdata[LED_W-1:0];
      if (ev_duty_wr) duty_q <= wdata[DUTY_W-1:0];
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_STAT: rd_next = status_word(tx_ready, rx_avail);
      SEL_RXD:  rd_next = XLEN'(rx_byte);
      SEL_CYC:  rd_next = XLEN'(cnt_q[CYC_IX]);
      SEL_INS:  rd_next = XLEN'(cnt_q[INS_IX]);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (ld_en) rdata <= rd_next;
  end

  assign unused_wdata_hi = ^wdata[XLEN-1:WIDEST];
endmodule

// File: rtl/mmio_hub_chk.sv
module mmio_hub_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned LED_W  = 16,
  parameter int unsigned DUTY_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_en,
  input logic              st_en,
  input logic              icount_en,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [7:0]        tx_byte,
  input logic              tx_push,
  input logic              rx_pop,
  input logic [LED_W-1:0]  led_q,
  input logic [DUTY_W-1:0] duty_q,
  input logic [CNT_W-1:0]  cyc_q,
  input logic [CNT_W-1:0]  ins_q,
  input logic              ev_clr,
  input logic              ev_tx_wr,
  input logic              ev_rx_rd
);
  // R6
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ev_clr |=> (cyc_q == '0 && ins_q == '0));

  // R5
  cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_clr |=> cyc_q == CNT_W'($past(cyc_q) + 1'b1));

  // R7
  ins_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ev_clr && !icount_en) |=> $stable(ins_q));

  // R7
  ins_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!ev_clr && icount_en) |=> ins_q == CNT_W'($past(ins_q) + 1'b1));

  // R4
  tx_push_chk: assert property (@(posedge clk) disable iff (rst)
    ev_tx_wr |=> (tx_push && tx_byte == $past(wdata[7:0])));

  // R4
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_tx_wr |=> (!tx_push && $stable(tx_byte)));

  // R3
  rx_pop_chk: assert property (@(posedge clk) disable iff (rst)
    ev_rx_rd |=> rx_pop);

  // R3
  rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_rx_rd |=> !rx_pop);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(rdata));

  // R8
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !st_en |=> ($stable(led_q) && $stable(duty_q)));
endmodule

bind mmio_hub mmio_hub_chk #(.CNT_W(CNT_W), .LED_W(LED_W), .DUTY_W(DUTY_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ld_en     (ld_en),
  .st_en     (st_en),
  .icount_en (icount_en),
  .wdata     (wdata),
  .rdata     (rdata),
  .tx_byte   (tx_byte),
  .tx_push   (tx_push),
  .rx_pop    (rx_pop),
  .led_q     (led_q),
  .duty_q    (duty_q),
  .cyc_q     (cnt_q[0]),
  .ins_q     (cnt_q[1]),
  .ev_clr    (ev_clr),
  .ev_tx_wr  (ev_tx_wr),
  .ev_rx_rd  (ev_rx_rd)
);

// File: tb/mmio_hub_test.sv
module mmio_hub_test;
  localparam logic [31:0] B      = 32'h8000_0000;
  localparam logic [31:0] A_STAT = B + 32'h00;
  localparam logic [31:0] A_RXD  = B + 32'h04;
  localparam logic [31:0] A_TXD  = B + 32'h08;
  localparam logic [31:0] A_CYC  = B + 32'h10;
  localparam logic [31:0] A_INS  = B + 32'h14;
  localparam logic [31:0] A_CLR  = B + 32'h18;
  localparam logic [31:0] A_LED  = B + 32'h30;
  localparam logic [31:0] A_DUTY = B + 32'h34;

  localparam logic [1:0] K_LED  = 2'd0;  // store, then expect led_q
  localparam logic [1:0] K_DUTY = 2'd1;  // store, then expect duty_q
  localparam logic [1:0] K_LOAD = 2'd2;  // load, then expect rdata
  localparam logic [1:0] K_STNO = 2'd3;  // store, expect {duty,led} unchanged, no push

  localparam int NV = 10;
  localparam logic [97:0] VECS [0:NV-1] = '{
    {K_LOAD, A_STAT,        32'h0,         32'h0000_0001},
    {K_LOAD, A_LED,         32'h0,         32'h0000_0000},
    {K_LED,  A_LED,         32'hDEAD_BEEF, 32'h0000_BEEF},
    {K_DUTY, A_DUTY,        32'h0000_5A5A, 32'h0000_0A5A},
    {K_STNO, B + 32'h38,    32'hFFFF_FFFF, 32'h0A5A_BEEF},
    {K_STNO, B + 32'h44,    32'h0000_0001, 32'h0A5A_BEEF},
    {K_LOAD, A_STAT,        32'h0,         32'h0000_0001},
    {K_LOAD, B + 32'h24,    32'h0,         32'h0000_0000},
    {K_LOAD, A_DUTY,        32'h0,         32'h0000_0000},
    {K_LED,  A_LED,         32'h0000_0001, 32'h0000_0001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] addr = '0, wdata = '0;
  logic st_en = 1'b0, ld_en = 1'b0, icount_en = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  tx_byte;
  logic        tx_push;
  logic        tx_ready = 1'b1;
  logic [7:0]  rx_byte = 8'h00;
  logic        rx_avail = 1'b0;
  logic        rx_pop;
  logic [15:0] led_q;
  logic [11:0] duty_q;

  int total = 0;
  int fails = 0;
  int wd = 0;
  logic [31:0] m_cyc = '0;   // reference cycle count from R5/R6
  logic [31:0] snap;

  always #10 clk = ~clk;     // 50 MHz

  mmio_hub uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .st_en(st_en),
    .ld_en(ld_en), .icount_en(icount_en), .rdata(rdata), .tx_byte(tx_byte),
    .tx_push(tx_push), .tx_ready(tx_ready), .rx_byte(rx_byte),
    .rx_avail(rx_avail), .rx_pop(rx_pop), .led_q(led_q), .duty_q(duty_q)
  );

  always @(posedge clk) begin
    if (rst)                          m_cyc <= '0;
    else if (st_en && addr == A_CLR)  m_cyc <= '0;
    else                              m_cyc <= m_cyc + 1;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 100000) begin
      total++; fails++;
      $display("FAIL watchdog all-reqs actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic load(input logic [31:0] a);
    ld_en = 1'b1; addr = a; snap = m_cyc;
    @(negedge clk);
    ld_en = 1'b0; addr = '0;
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d);
    st_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    st_en = 1'b0; addr = '0; wdata = '0;
  endtask

  initial begin
    logic [31:0] v1, v2, prev;
    int highs;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 led", 32'(led_q), 32'h0);
    chk("R1 duty", 32'(duty_q), 32'h0);
    chk("R1 strobes", {30'h0, tx_push, rx_pop}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    // R1: counters start at zero (instruction counter never enabled yet)
    load(A_INS);
    chk("R1 ins after reset", rdata, 32'h0);

    // Table walk: R2, R8, R9
    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      logic [31:0] a, d, e;
      {k, a, d, e} = VECS[i];
      case (k)
        K_LED:  begin store(a, d); chk("R8 led_q", 32'(led_q), e); end
        K_DUTY: begin store(a, d); chk("R8 duty_q", 32'(duty_q), e); end
        K_LOAD: begin load(a); chk("R2/R8/R9 load", rdata, e); end
        default: begin
          store(a, d);
          chk("R9 unmapped store regs", {4'h0, duty_q, led_q}, e);
          chk("R9 unmapped store push", 32'(tx_push), 32'h0);
        end
      endcase
    end

    // R2: status with other handshake combinations
    tx_ready = 1'b0; rx_avail = 1'b1;
    load(A_STAT); chk("R2 status rx only", rdata, 32'h2);
    tx_ready = 1'b1;
    load(A_STAT); chk("R2 status both", rdata, 32'h3);

    // R3 / R10: receive byte, pop strobe, registered timing
    rx_byte = 8'hC3;
    prev = rdata;
    ld_en = 1'b1; addr = A_RXD;
    #1 chk("R10 rdata before edge", rdata, prev);
    @(negedge clk);
    ld_en = 1'b0; addr = '0;
    chk("R3 rx byte", rdata, 32'h0000_00C3);
    chk("R3 pop high", 32'(rx_pop), 32'h1);
    rx_avail = 1'b0;
    @(negedge clk);
    chk("R3 pop single", 32'(rx_pop), 32'h0);
    repeat (3) @(negedge clk);
    chk("R10 rdata hold", rdata, 32'h0000_00C3);

    // R4: transmit store
    store(A_TXD, 32'h1234_5677);
    chk("R4 push", 32'(tx_push), 32'h1);
    chk("R4 byte", 32'(tx_byte), 32'h77);
    @(negedge clk);
    chk("R4 push single", 32'(tx_push), 32'h0);
    chk("R4 byte held", 32'(tx_byte), 32'h77);

    // R5: cycle counter absolute and relative
    load(A_CYC); v1 = rdata;
    chk("R5 cyc value", v1, snap);
    repeat (5) @(negedge clk);
    load(A_CYC); v2 = rdata;
    chk("R5 cyc delta", v2 - v1, 32'd6);

    // R6: clear collides with both increments (icount_en high)
    icount_en = 1'b1;
    store(A_CLR, 32'h0);
    icount_en = 1'b0;
    load(A_INS); chk("R6 ins clear wins", rdata, 32'h0);
    store(A_CLR, 32'hFFFF_FFFF);
    load(A_CYC); chk("R6 cyc after clear", rdata, 32'h0);
    load(A_CYC); chk("R6 cyc next", rdata, 32'h1);

    // R7: instruction counter follows the enable pattern
    store(A_CLR, 32'h0);
    highs = 0;
    for (int i = 0; i < 10; i++) begin
      icount_en = (i % 3 != 0);
      if (icount_en) highs++;
      @(negedge clk);
    end
    icount_en = 1'b0;
    load(A_INS); chk("R7 ins count", rdata, 32'(highs));
    repeat (4) @(negedge clk);
    load(A_INS); chk("R7 ins held", rdata, 32'(highs));

    summary();
    $finish;
  end
endmodule